// File: doc/BRIEF.md
# Flash Program/Erase Sequencer With Suspend

This block runs two kinds of operation against a command-driven flash part over a 16-bit command/data bus: a halfword program at a given address, and a block erase. It writes the command words in the required order, then polls the flash status word until the part reports ready. Before a program it reads the current contents of the target word. If the new value needs any bit to go from 0 back to 1, it rejects the request.

An erase can run for a long time, so it can be paused. When the interrupt-request input rises while the block is polling an erase, the block suspends the erase and waits for the suspend to settle. It then checks whether the erase finished anyway.

- If the erase finished, the operation ends at once.
- If it did not, the block returns the flash to array mode, stops using the bus and raises a release flag. The host then services its interrupt. When the host grants the bus back, the block resumes the erase and issues a fresh read-status before it polls again.

Every operation finishes with a read-array command. Completion is reported by a one-cycle done pulse, together with error when the request was refused.

Top module: `flash_op_seq`

## Requirements
- R1: After reset, busy, done, error, hostRun, fWrEn and fRdEn are all 0.
- R2: A program request whose value has a 1 in any bit where the word currently read at the target address has a 0 is refused. The block does one read in the cycle after acceptance, writes nothing, and pulses done and error together.
- R3: An accepted program writes, in this order: 0x60, 0xD0 (unlock, only when UNLOCK_EN=1), then 0x50, 0x40, the data word, and 0xFF once status bit 7 reads 1. Afterwards the flash holds the new value.
- R4: An erase writes, in this order: 0x60, 0xD0 (unlock, only when UNLOCK_EN=1), then 0x50, 0x20, 0xD0, 0x70. It then polls status bit 7 and writes 0xFF when the bit reads 1.
- R5: While status bit 7 reads 0, the block keeps reading status and writes nothing.
- R6: A rising edge of irqReq seen while an erase is polling and bit 7 is 0 causes writes of 0xB0 then 0x70. The block then polls status until bit 7 is 1.
- R7: If status bit 6 reads 0 once the suspend settles, the block writes 0xFF and ends the operation with done. It never raises hostRun.
- R8: If status bit 6 reads 1 once the suspend settles, the block writes 0xFF and holds hostRun high with no bus activity until hostGrant is 1. It then writes 0xD0 and 0x70 and resumes polling.
- R9: reqValid is ignored while busy is 1, and a rising irqReq during a program has no effect on its command sequence.
- R10: done is high for exactly one cycle per operation, in the cycle after the last bus write (or after the refusing read), with busy already 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken only when idle |
| reqErase | input | 1 | 1 = block erase, 0 = halfword program |
| reqAddr | input | ADDR_W | Target word or block address |
| reqData | input | DATA_W | Value to program |
| irqReq | input | 1 | Interrupt request; a rising edge suspends an erase |
| hostGrant | input | 1 | Host returns the bus after a release |
| hostRun | output | 1 | Bus released; host may run |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Request refused; coincides with done |
| fAddr | output | ADDR_W | Flash address |
| fWrEn | output | 1 | Flash write strobe |
| fWrData | output | DATA_W | Command or data word |
| fRdEn | output | 1 | Flash read strobe |
| fRdData | input | DATA_W | Flash read data, valid in the cycle fRdEn is high |

## Verification
The properties assume a flash that returns read data in the same cycle the read strobe is high. They also assume a host that leaves hostGrant low except while it is handing the bus back. The bench's flash model answers combinationally, and its status word carries ready in bit 7 and suspended in bit 6. The bench pulses hostGrant for a single cycle, only after it has seen hostRun. It raises irqReq only at points where the sequencer is known to be polling an erase or running a program.

// File: rtl/flash_op_pkg.sv
package flash_op_pkg;

  localparam logic [7:0] OP_CFG     = 8'h60;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_CLRSTAT = 8'h50;
  localparam logic [7:0] OP_PROG    = 8'h40;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_RDSTAT  = 8'h70;
  localparam logic [7:0] OP_SUSPEND = 8'hB0;
  localparam logic [7:0] OP_ARRAY   = 8'hFF;

  localparam int READY_BIT = 7;
  localparam int SUSP_BIT  = 6;

  typedef enum logic [3:0] {
    W_CFG, W_CONFIRM, W_CLRSTAT, W_PROG, W_ERASE,
    W_RDSTAT, W_SUSPEND, W_ARRAY, W_DATA
  } wordSel_e;

  typedef struct packed {
    logic     load;
    logic     wrEn;
    logic     rdEn;
    wordSel_e sel;
  } dpCtl_t;

endpackage

// File: rtl/flash_op_dp.sv
module flash_op_dp
  import flash_op_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] fRdData,
  output logic              conflict,
  output logic [ADDR_W-1:0] fAddr,
  output logic              fWrEn,
  output logic [DATA_W-1:0] fWrData,
  output logic              fRdEn
);

  localparam int PAD_W = DATA_W - 8;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [7:0]        opByte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (ctl.load) begin
      addrQ <= reqAddr;
      dataQ <= reqData;
    end
  end

  always_comb begin
    case (ctl.sel)
      W_CFG:     opByte = OP_CFG;
      W_CONFIRM: opByte = OP_CONFIRM;
      W_CLRSTAT: opByte = OP_CLRSTAT;
      W_PROG:    opByte = OP_PROG;
      W_ERASE:   opByte = OP_ERASE;
      W_RDSTAT:  opByte = OP_RDSTAT;
      W_SUSPEND: opByte = OP_SUSPEND;
      default:   opByte = OP_ARRAY;
    endcase
  end

  assign fWrData  = (ctl.sel == W_DATA) ? dataQ : {{PAD_W{1'b0}}, opByte};
  assign fWrEn    = ctl.wrEn;
  assign fRdEn    = ctl.rdEn;
  assign fAddr    = addrQ;
  assign conflict = |(~fRdData & dataQ);

endmodule

// File: rtl/flash_op_ctrl.sv
module flash_op_ctrl
  import flash_op_pkg::*;
#(
  parameter bit UNLOCK_EN = 1'b1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   reqValid,
  input  logic   reqErase,
  input  logic   irqReq,
  input  logic   hostGrant,
  input  logic   statReady,
  input  logic   statSusp,
  input  logic   conflict,
  output dpCtl_t ctl,
  output logic   hostRun,
  output logic   busy,
  output logic   done,
  output logic   error
);

  typedef enum logic [4:0] {
    S_IDLE, S_CHECK, S_UNLK_A, S_UNLK_B, S_CLR, S_SETUP, S_ARG, S_RDST,
    S_POLL, S_SUSP, S_SUSP_RS, S_SUSP_POLL, S_PARK, S_HOLD, S_RESUME,
    S_RES_RS, S_FIN
  } state_e;

  localparam state_e FIRST_WR = UNLOCK_EN ? S_UNLK_A : S_CLR;

  state_e st, nxt;
  logic   eraseOp, irqQ, irqRise, finish, reject;

  assign irqRise = irqReq && !irqQ;

  always_comb begin
    nxt      = st;
    ctl.load = 1'b0;
    ctl.wrEn = 1'b0;
    ctl.rdEn = 1'b0;
    ctl.sel  = W_ARRAY;
    finish   = 1'b0;
    reject   = 1'b0;
    case (st)
      S_IDLE: if (reqValid) begin
        ctl.load = 1'b1;
        nxt = reqErase ? FIRST_WR : S_CHECK;
      end
      S_CHECK: begin
        ctl.rdEn = 1'b1;
        if (conflict) begin reject = 1'b1; nxt = S_IDLE; end
        else nxt = FIRST_WR;
      end
      S_UNLK_A: begin ctl.wrEn = 1'b1; ctl.sel = W_CFG;     nxt = S_UNLK_B; end
      S_UNLK_B: begin ctl.wrEn = 1'b1; ctl.sel = W_CONFIRM; nxt = S_CLR; end
      S_CLR:    begin ctl.wrEn = 1'b1; ctl.sel = W_CLRSTAT; nxt = S_SETUP; end
      S_SETUP: begin
        ctl.wrEn = 1'b1;
        ctl.sel  = eraseOp ? W_ERASE : W_PROG;
        nxt      = S_ARG;
      end
      S_ARG: begin
        ctl.wrEn = 1'b1;
        ctl.sel  = eraseOp ? W_CONFIRM : W_DATA;
        nxt      = eraseOp ? S_RDST : S_POLL;
      end
      S_RDST: begin ctl.wrEn = 1'b1; ctl.sel = W_RDSTAT; nxt = S_POLL; end
      S_POLL: begin
        ctl.rdEn = 1'b1;
        if (statReady) nxt = S_FIN;
        else if (eraseOp && irqRise) nxt = S_SUSP;
      end
      S_SUSP:    begin ctl.wrEn = 1'b1; ctl.sel = W_SUSPEND; nxt = S_SUSP_RS; end
      S_SUSP_RS: begin ctl.wrEn = 1'b1; ctl.sel = W_RDSTAT;  nxt = S_SUSP_POLL; end
      S_SUSP_POLL: begin
        ctl.rdEn = 1'b1;
        if (statReady) nxt = statSusp ? S_PARK : S_FIN;
      end
      S_PARK:   begin ctl.wrEn = 1'b1; ctl.sel = W_ARRAY;   nxt = S_HOLD; end
      S_HOLD:   if (hostGrant) nxt = S_RESUME;
      S_RESUME: begin ctl.wrEn = 1'b1; ctl.sel = W_CONFIRM; nxt = S_RES_RS; end
      S_RES_RS: begin ctl.wrEn = 1'b1; ctl.sel = W_RDSTAT;  nxt = S_POLL; end
      S_FIN: begin
        ctl.wrEn = 1'b1;
        ctl.sel  = W_ARRAY;
        finish   = 1'b1;
        nxt      = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      eraseOp <= 1'b0;
      irqQ    <= 1'b0;
      done    <= 1'b0;
      error   <= 1'b0;
    end else begin
      st    <= nxt;
      irqQ  <= irqReq;
      done  <= finish || reject;
      error <= reject;
      if (ctl.load) eraseOp <= reqErase;
    end
  end

  assign hostRun = (st == S_HOLD);
  assign busy    = (st != S_IDLE);

endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
  import flash_op_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter bit UNLOCK_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqErase,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              irqReq,
  input  logic              hostGrant,
  output logic              hostRun,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [ADDR_W-1:0] fAddr,
  output logic              fWrEn,
  output logic [DATA_W-1:0] fWrData,
  output logic              fRdEn,
  input  logic [DATA_W-1:0] fRdData
);

  dpCtl_t ctl;
  logic   conflict;

  flash_op_ctrl #(.UNLOCK_EN(UNLOCK_EN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqErase(reqErase),
    .irqReq(irqReq), .hostGrant(hostGrant),
    .statReady(fRdData[READY_BIT]), .statSusp(fRdData[SUSP_BIT]),
    .conflict(conflict), .ctl(ctl), .hostRun(hostRun), .busy(busy),
    .done(done), .error(error)
  );

  flash_op_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .reqAddr(reqAddr), .reqData(reqData),
    .fRdData(fRdData), .conflict(conflict), .fAddr(fAddr), .fWrEn(fWrEn),
    .fWrData(fWrData), .fRdEn(fRdEn)
  );

endmodule

// File: rtl/flash_op_seq_chk.sv
module flash_op_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic error,
  input logic hostRun,
  input logic hostGrant,
  input logic fWrEn,
  input logic fRdEn
);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2
  error_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);

  // R8
  released_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hostRun |-> (!fWrEn && !fRdEn));

  // R8
  hold_until_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hostRun && !hostGrant) |=> hostRun);

  // R9
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!fWrEn && !fRdEn));

  // R5
  no_rw_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fWrEn && fRdEn));

endmodule

bind flash_op_seq flash_op_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .error(error),
  .hostRun(hostRun), .hostGrant(hostGrant), .fWrEn(fWrEn), .fRdEn(fRdEn)
);

// File: tb/flash_op_seq_bench.sv
module flash_op_seq_bench;

  localparam int AW = 4;
  localparam int DW = 16;
  localparam int ERASE_CYC = 20;
  localparam int PROG_CYC  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reqValid = 1'b0, reqErase = 1'b0, irqReq = 1'b0, hostGrant = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic          hostRun, busy, done, error, fWrEn, fRdEn;
  logic [AW-1:0] fAddr;
  logic [DW-1:0] fWrData, fRdData;

  always #5 clk = ~clk;

  flash_op_seq #(.ADDR_W(AW), .DATA_W(DW), .UNLOCK_EN(1'b1)) u_flash_op_seq (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqErase(reqErase),
    .reqAddr(reqAddr), .reqData(reqData), .irqReq(irqReq), .hostGrant(hostGrant),
    .hostRun(hostRun), .busy(busy), .done(done), .error(error), .fAddr(fAddr),
    .fWrEn(fWrEn), .fWrData(fWrData), .fRdEn(fRdEn), .fRdData(fRdData)
  );

  // Flash model: status word has ready in bit 7, suspended in bit 6
  logic [DW-1:0] mem [16];
  logic          statMode, cfgPend, eraseSetup, progPend, erasing, susp, forceFinish;
  int            eraseCnt, progCnt;
  logic          ready;

  assign ready   = (progCnt == 0) && !(erasing && !susp);
  assign fRdData = statMode ? {8'h00, ready, susp, 6'h00} : mem[fAddr];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= '1;
      statMode <= 1'b0; cfgPend <= 1'b0; eraseSetup <= 1'b0; progPend <= 1'b0;
      erasing <= 1'b0; susp <= 1'b0; eraseCnt <= 0; progCnt <= 0;
    end else begin
      if (progCnt > 0) progCnt <= progCnt - 1;
      if (erasing && !susp) begin
        if (eraseCnt <= 1) begin
          erasing <= 1'b0;
          for (int i = 0; i < 16; i++) mem[i] <= '1;
        end
        eraseCnt <= eraseCnt - 1;
      end
      if (fWrEn) begin
        cfgPend <= 1'b0;
        eraseSetup <= 1'b0;
        if (progPend) begin
          progPend <= 1'b0;
          mem[fAddr] <= mem[fAddr] & fWrData;
          progCnt <= PROG_CYC;
        end else begin
          case (fWrData[7:0])
            8'h60: cfgPend <= 1'b1;
            8'h40: begin progPend <= 1'b1; statMode <= 1'b1; end
            8'h20: begin eraseSetup <= 1'b1; statMode <= 1'b1; end
            8'h70: statMode <= 1'b1;
            8'hFF: statMode <= 1'b0;
            8'hB0: if (erasing) begin
              statMode <= 1'b1;
              if (forceFinish) begin
                erasing <= 1'b0;
                for (int i = 0; i < 16; i++) mem[i] <= '1;
              end else susp <= 1'b1;
            end
            8'hD0: if (!cfgPend) begin
              statMode <= 1'b1;
              if (eraseSetup) begin erasing <= 1'b1; eraseCnt <= ERASE_CYC; end
              else if (susp) susp <= 1'b0;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // Write log
  logic [DW-1:0] logW [1024];
  int            logN = 0;
  always @(posedge clk) if (fWrEn && logN < 1024) begin
    logW[logN] <= fWrData;
    logN <= logN + 1;
  end

  int checks = 0, errors = 0;
  logic [DW-1:0] expW [16];
  int expN, logStart;
  logic [DW-1:0] shadow;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expPush(input logic [DW-1:0] w);
    expW[expN] = w;
    expN++;
  endtask

  task automatic chkSeq(input string req);
    chk(logN - logStart == expN, req, logN - logStart, expN);
    for (int i = 0; i < expN; i++)
      if (logStart + i < logN)
        chk(logW[logStart + i] == expW[i], req, logW[logStart + i], expW[i]);
  endtask

  task automatic request(input logic er, input logic [AW-1:0] a, input logic [DW-1:0] d);
    logStart = logN;
    expN = 0;
    reqErase = er; reqAddr = a; reqData = d; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk(done == 1'b1, req, done, 1);
    @(negedge clk);
    // R10: one-cycle pulse
    chk(done == 1'b0 && busy == 1'b0, "R10", {done, busy}, 0);
  endtask

  task automatic expUnlock();
    expPush(16'h0060); expPush(16'h00D0);
  endtask

  task automatic doProgram(input logic [AW-1:0] a, input logic [DW-1:0] v);
    logic rej;
    shadow = mem[a];
    rej = |(~shadow & v);
    request(1'b0, a, v);
    waitDone(rej ? "R2" : "R3");
    // error flag sampled in the done cycle was checked via the assertion; here check the result
    if (rej) begin
      chkSeq("R2");
      chk(mem[a] == shadow, "R2", mem[a], shadow);
    end else begin
      expUnlock(); expPush(16'h0050); expPush(16'h0040); expPush(v); expPush(16'h00FF);
      chkSeq("R3");
      chk(mem[a] == v, "R3", mem[a], v);
    end
  endtask

  task automatic expEraseHead();
    expUnlock(); expPush(16'h0050); expPush(16'h0020); expPush(16'h00D0); expPush(16'h0070);
  endtask

  initial begin
    fork
      begin
        forceFinish = 1'b0;
        repeat (3) @(negedge clk);
        // R1
        chk({busy, done, error, hostRun, fWrEn, fRdEn} == 6'b0, "R1",
            {busy, done, error, hostRun, fWrEn, fRdEn}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, error, hostRun, fWrEn, fRdEn} == 6'b0, "R1",
            {busy, done, error, hostRun, fWrEn, fRdEn}, 0);

        // Error flag observed in the done cycle: R2
        begin
          logic seenErr;
          request(1'b0, 4'd0, 16'h00F0);
          waitDone("R3");
          request(1'b0, 4'd0, 16'h0F00);
          seenErr = 1'b0;
          for (int i = 0; i < 10; i++) begin
            if (done) seenErr = error;
            @(negedge clk);
          end
          chk(seenErr == 1'b1, "R2", seenErr, 1);
          chk(logN == logStart, "R2", logN - logStart, 0);
        end

        // R4: plain erase
        request(1'b1, 4'd5, 16'h0000);
        waitDone("R4");
        expEraseHead(); expPush(16'h00FF);
        chkSeq("R4");
        chk(mem[0] == 16'hFFFF, "R4", mem[0], 16'hFFFF);

        // Program sweep: clear one bit, refuse setting it, clear a second bit
        for (int k = 0; k < 16; k++) begin
          doProgram(k[AW-1:0], ~(16'h1 << k));
          doProgram(k[AW-1:0], 16'h1 << k);
          doProgram(k[AW-1:0], ~((16'h1 << k) | (16'h1 << ((k + 1) % 16))));
        end

        // R5: polling writes nothing for the whole erase wait
        begin
          int wr = 0;
          request(1'b1, 4'd0, 16'h0);
          repeat (8) @(negedge clk);
          wr = logN;
          repeat (8) @(negedge clk);
          chk(logN == wr && fRdEn == 1'b1, "R5", logN - wr, 0);
          waitDone("R5");
        end

        // R9: request while busy ignored; irq during program ignored
        request(1'b1, 4'd0, 16'h0);
        repeat (4) @(negedge clk);
        reqErase = 1'b0; reqAddr = 4'd3; reqData = 16'h0000; reqValid = 1'b1;
        @(negedge clk);
        reqValid = 1'b0;
        waitDone("R9");
        expEraseHead(); expPush(16'h00FF);
        chkSeq("R9");
        chk(mem[3] == 16'hFFFF, "R9", mem[3], 16'hFFFF);

        request(1'b0, 4'd2, 16'h1234);
        repeat (5) @(negedge clk);
        irqReq = 1'b1;
        waitDone("R9");
        irqReq = 1'b0;
        expUnlock(); expPush(16'h0050); expPush(16'h0040); expPush(16'h1234); expPush(16'h00FF);
        chkSeq("R9");
        chk(hostRun == 1'b0, "R9", hostRun, 0);

        // R6/R8: suspend, release, resume
        begin
          int held;
          request(1'b1, 4'd0, 16'h0);
          repeat (10) @(negedge clk);
          irqReq = 1'b1;
          for (int i = 0; i < 20 && !hostRun; i++) @(negedge clk);
          chk(hostRun == 1'b1, "R8", hostRun, 1);
          held = logN;
          repeat (6) @(negedge clk);
          chk(hostRun == 1'b1 && logN == held && !fRdEn, "R8", logN - held, 0);
          chk(statMode == 1'b0, "R8", statMode, 0);
          hostGrant = 1'b1;
          @(negedge clk);
          hostGrant = 1'b0;
          irqReq = 1'b0;
          chk(hostRun == 1'b0, "R8", hostRun, 0);
          waitDone("R8");
          expEraseHead(); expPush(16'h00B0); expPush(16'h0070); expPush(16'h00FF);
          expPush(16'h00D0); expPush(16'h0070); expPush(16'h00FF);
          chkSeq("R6");
          chk(mem[9] == 16'hFFFF, "R8", mem[9], 16'hFFFF);
        end

        // R7: erase completes during suspend
        begin
          logic sawRun = 1'b0;
          doProgram(4'd9, 16'h0000);
          forceFinish = 1'b1;
          request(1'b1, 4'd0, 16'h0);
          repeat (10) @(negedge clk);
          irqReq = 1'b1;
          for (int i = 0; i < 40 && !done; i++) begin
            sawRun |= hostRun;
            @(negedge clk);
          end
          irqReq = 1'b0;
          chk(done == 1'b1 && !sawRun, "R7", {done, sawRun}, 2'b10);
          @(negedge clk);
          expEraseHead(); expPush(16'h00B0); expPush(16'h0070); expPush(16'h00FF);
          chkSeq("R7");
          chk(mem[9] == 16'hFFFF, "R7", mem[9], 16'hFFFF);
          forceFinish = 1'b0;
        end
      end
      begin
        repeat (150000) @(negedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule